// File: doc/BRIEF.md
# PWM Compare-Word Router

The router sits between a PWM sequencer and the wave counter. When the sequencer asks for a new step, the router reads one, two or four 16-bit parameter half-words from a synchronous memory read port. It stages them in shadow registers. At the next period boundary after the whole step has arrived, it moves them into the four live channel registers together, as one update. In every half-word, bit 15 is the channel polarity and bits 14:0 are the compare value.

A 2-bit load mode decides how many half-words make up one step and how they are spread over the channels. In WaveForm mode the fourth half-word becomes the counter top value, so the PWM frequency can change from one step to the next. If the next step is not complete when a period ends, the live registers keep their values and the previous compare words repeat for another period, so the outputs never glitch.

The control is a four-state machine:
- IDLE: waiting for a step request.
- ISSUE: drives a single-cycle memory request.
- WAIT: waits for the read data.
- READY: the step is complete and waits for the period-end strobe.

The transitions are:
- START: IDLE to ISSUE, on a step request.
- SENT: ISSUE to WAIT.
- NEXT_WORD: WAIT to ISSUE, when data arrives and more words are due.
- LAST_WORD: WAIT to READY, when the last word of the step arrives.
- COMMIT: READY to IDLE, on the period-end strobe.

Top module: `pwm_word_router`

## Requirements
- R1: After reset, all channel compare values and polarities are 0, `ch_en` is 0, `top_val` equals the TOP_RST parameter, and `mem_req` and `step_ready` are low.
- R2: Let W be the number of half-words per step (1, 2 or 4). Half-word j of step k is read from byte address base + (k·W + j)·2, for j = 0 up to W−1 in ascending order.
- R3: Load mode 0 (Common), W=1: the single half-word goes to all four channels, and `ch_en` = 4'b1111.
- R4: Load mode 1 (Grouped), W=2: half-word 0 goes to channels 0 and 1, half-word 1 goes to channels 2 and 3, and `ch_en` = 4'b1111.
- R5: Load mode 2 (Individual), W=4: half-word i goes to channel i, and `ch_en` = 4'b1111.
- R6: Load mode 3 (WaveForm), W=4: half-words 0 to 2 go to channels 0 to 2, and bits 14:0 of half-word 3 become `top_val`. The `reg_top` input is ignored. Channel 3 reads compare 0 with polarity 0, and `ch_en` = 4'b0111.
- R7: In modes 0 to 2, `top_val` takes the value `reg_top` has in the cycle of the commit, not the value it had when the step was requested.
- R8: `step_ready` rises once every half-word of a step has arrived, and it stays high until a `period_end` strobe. That strobe commits all channel words and the top value in one clock edge. No other edge changes the live outputs.
- R9: A `period_end` strobe that arrives while the step is still being fetched leaves the live outputs unchanged. The pending step commits at a later strobe.
- R10: A `step_req` received while a step is being fetched or waiting to commit is ignored: it causes no extra memory read and does not change the step being fetched.
- R11: At most one memory read is outstanding. `mem_req` is a single-cycle pulse, and the next one is issued only after `mem_valid` returns the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_req | input | 1 | Step request pulse from the sequencer |
| step_idx | input | IDX_W | Index of the step within the sequence |
| base_addr | input | ADDR_W | Byte address of the start of the sequence |
| load_mode | input | 2 | Routing mode: 0 Common, 1 Grouped, 2 Individual, 3 WaveForm |
| reg_top | input | 15 | Counter top value from the register, used in modes 0 to 2 |
| period_end | input | 1 | Strobe marking the end of a PWM period |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data half-word |
| ch_cmp | output | 60 | Live compare values; channel c is in bits 15c+14 down to 15c |
| ch_pol | output | 4 | Live polarity bits, one per channel |
| ch_en | output | 4 | Active-channel mask of the live step |
| top_val | output | 15 | Live counter top value |
| step_ready | output | 1 | A staged step is complete and waits for the period end |

## Verification
The bench uses the default parameters: 16-bit addresses, 8-bit step indices and a reset top value of 1023. It sweeps all four load modes over step indices 0 to 3, with a different base address for each mode. The memory model runs once with a read latency of 1 cycle and once with 3 cycles. The 3-cycle run keeps the fetch in progress long enough for a period-end strobe and a stray step request to arrive mid-step. This makes the repeat-previous-values and ignore-request cases reachable. Every memory word is an arithmetic function of its address, so the bench predicts each routed compare value, polarity and top value.

// File: rtl/pwm_dec_pkg.sv
package pwm_dec_pkg;
    localparam int NCH   = 4;
    localparam int CMP_W = 15;
    localparam int HW_W  = CMP_W + 1;
    localparam int WC_W  = $clog2(NCH);

    typedef enum logic [1:0] {
        LD_COMMON  = 2'd0,
        LD_GROUPED = 2'd1,
        LD_INDIV   = 2'd2,
        LD_WAVE    = 2'd3
    } load_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_READY
    } dec_state_e;

    // log2 of the number of half-words in one step
    function automatic logic [1:0] step_shift(load_mode_e m);
        unique case (m)
            LD_COMMON:  return 2'd0;
            LD_GROUPED: return 2'd1;
            default:    return 2'd2;
        endcase
    endfunction

    // shadow slot that feeds channel ch
    function automatic logic [WC_W-1:0] src_slot(load_mode_e m, int ch);
        unique case (m)
            LD_COMMON:  return '0;
            LD_GROUPED: return WC_W'(ch / 2);
            default:    return WC_W'(ch);
        endcase
    endfunction
endpackage

// File: rtl/pwm_step_ctx.sv
module pwm_step_ctx
    import pwm_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [IDX_W-1:0]     step_idx,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [1:0]           load_mode,
    input  logic [WC_W-1:0]      wcnt,
    output load_mode_e           mode_q,
    output logic [WC_W-1:0]      words_m1,
    output logic [ADDR_W-1:0]    mem_addr
);
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        sh;
    logic [ADDR_W-1:0] hw_ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
            mode_q <= LD_COMMON;
        end else if (accept) begin
            idx_q  <= step_idx;
            base_q <= base_addr;
            mode_q <= load_mode_e'(load_mode);
        end
    end

    always_comb begin
        sh       = step_shift(mode_q);
        words_m1 = WC_W'((1 << sh) - 1);
        hw_ofs   = (ADDR_W'(idx_q) << sh) + ADDR_W'(wcnt);
        mem_addr = base_q + (hw_ofs << 1);
    end

    // R10: the latched step context only moves on an accepted request
    // R10
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(idx_q) && $stable(base_q) && $stable(mode_q)));
endmodule

// File: rtl/pwm_step_fsm.sv
module pwm_step_fsm
    import pwm_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_req,
    input  logic            period_end,
    input  logic            mem_valid,
    input  logic [WC_W-1:0] words_m1,
    output logic            accept,
    output logic            mem_req,
    output logic            word_wr,
    output logic [WC_W-1:0] wcnt,
    output logic            step_ready,
    output logic            commit
);
    dec_state_e state, state_nx;
    logic [WC_W-1:0] wcnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            wcnt  <= wcnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        wcnt_nx  = wcnt;
        unique case (state)
            ST_IDLE: if (step_req) begin              // START
                state_nx = ST_ISSUE;
                wcnt_nx  = '0;
            end
            ST_ISSUE: state_nx = ST_WAIT;             // SENT
            ST_WAIT: if (mem_valid) begin
                if (wcnt == words_m1) begin
                    state_nx = ST_READY;              // LAST_WORD
                end else begin
                    state_nx = ST_ISSUE;              // NEXT_WORD
                    wcnt_nx  = wcnt + 1'b1;
                end
            end
            ST_READY: if (period_end) state_nx = ST_IDLE;  // COMMIT
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept     = (state == ST_IDLE) && step_req;
        mem_req    = (state == ST_ISSUE);
        word_wr    = (state == ST_WAIT) && mem_valid;
        step_ready = (state == ST_READY);
        commit     = (state == ST_READY) && period_end;
    end

    // R11
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ready && !period_end) |=> step_ready);
    // R11
    req_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, step_ready}));
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_dec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      word_wr,
    input  logic [WC_W-1:0]           wcnt,
    input  logic [HW_W-1:0]           mem_rdata,
    output logic [NCH-1:0][HW_W-1:0]  shadow
);
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[g] <= '0;
            else if (word_wr && (wcnt == WC_W'(g)))
                shadow[g] <= mem_rdata;
        end
    end
endmodule

// File: rtl/pwm_live_regs.sv
module pwm_live_regs
    import pwm_dec_pkg::*;
#(
    parameter logic [CMP_W-1:0] TOP_RST = 15'd1023
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  load_mode_e                mode_q,
    input  logic [NCH-1:0][HW_W-1:0]  shadow,
    input  logic [CMP_W-1:0]          reg_top,
    output logic [NCH*CMP_W-1:0]      ch_cmp,
    output logic [NCH-1:0]            ch_pol,
    output logic [NCH-1:0]            ch_en,
    output logic [CMP_W-1:0]          top_val
);
    localparam logic [NCH-1:0] WAVE_EN = NCH'((1 << (NCH - 1)) - 1);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [HW_W-1:0] pick;
        always_comb begin
            if (mode_q == LD_WAVE && g == NCH - 1)
                pick = '0;
            else
                pick = shadow[src_slot(mode_q, g)];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_cmp[g*CMP_W +: CMP_W] <= '0;
                ch_pol[g]                <= 1'b0;
            end else if (commit) begin
                ch_cmp[g*CMP_W +: CMP_W] <= pick[CMP_W-1:0];
                ch_pol[g]                <= pick[HW_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_val <= TOP_RST;
            ch_en   <= '0;
        end else if (commit) begin
            top_val <= (mode_q == LD_WAVE) ? shadow[NCH-1][CMP_W-1:0] : reg_top;
            ch_en   <= (mode_q == LD_WAVE) ? WAVE_EN : '1;
        end
    end

    // R8
    live_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ch_cmp) && $stable(ch_pol) && $stable(top_val) && $stable(ch_en)));
    // R6
    wave_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode_q == LD_WAVE) |=> (top_val == $past(shadow[NCH-1][CMP_W-1:0])
                                           && ch_pol[NCH-1] == 1'b0));
endmodule

// File: rtl/pwm_word_router.sv
module pwm_word_router
    import pwm_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter logic [14:0] TOP_RST = 15'd1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_req,
    input  logic [IDX_W-1:0]  step_idx,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        load_mode,
    input  logic [14:0]       reg_top,
    input  logic              period_end,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic [59:0]       ch_cmp,
    output logic [3:0]        ch_pol,
    output logic [3:0]        ch_en,
    output logic [14:0]       top_val,
    output logic              step_ready
);
    logic                     accept, word_wr, commit;
    logic [WC_W-1:0]          wcnt, words_m1;
    load_mode_e               mode_q;
    logic [NCH-1:0][HW_W-1:0] shadow;

    pwm_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .period_end(period_end),
        .mem_valid(mem_valid), .words_m1(words_m1), .accept(accept),
        .mem_req(mem_req), .word_wr(word_wr), .wcnt(wcnt),
        .step_ready(step_ready), .commit(commit)
    );

    pwm_step_ctx #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .accept(accept), .step_idx(step_idx),
        .base_addr(base_addr), .load_mode(load_mode), .wcnt(wcnt),
        .mode_q(mode_q), .words_m1(words_m1), .mem_addr(mem_addr)
    );

    pwm_shadow_bank u_shadow (
        .clk(clk), .rst_n(rst_n), .word_wr(word_wr), .wcnt(wcnt),
        .mem_rdata(mem_rdata), .shadow(shadow)
    );

    pwm_live_regs #(.TOP_RST(TOP_RST)) u_live (
        .clk(clk), .rst_n(rst_n), .commit(commit), .mode_q(mode_q),
        .shadow(shadow), .reg_top(reg_top), .ch_cmp(ch_cmp), .ch_pol(ch_pol),
        .ch_en(ch_en), .top_val(top_val)
    );

    // R9
    early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !step_ready) |=> ($stable(ch_cmp) && $stable(top_val)));
endmodule

// File: tb/pwm_word_router_tb.sv
module pwm_word_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_req = 1'b0;
    logic [7:0]  step_idx = '0;
    logic [15:0] base_addr = '0;
    logic [1:0]  load_mode = '0;
    logic [14:0] reg_top = '0;
    logic        period_end = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid;
    logic [15:0] mem_rdata;
    logic [59:0] ch_cmp;
    logic [3:0]  ch_pol, ch_en;
    logic [14:0] top_val;
    logic        step_ready;

    int n_chk = 0, n_bad = 0;
    int lat = 1;
    logic clr_log = 1'b0;
    int req_cnt, pend;
    logic [15:0] pend_addr;
    logic [15:0] req_log [0:7];
    logic [59:0] exp_cmp = '0;
    logic [3:0]  exp_pol = '0, exp_en = '0;
    logic [14:0] exp_top = 15'd1023;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_word_router u_dut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_idx(step_idx),
        .base_addr(base_addr), .load_mode(load_mode), .reg_top(reg_top),
        .period_end(period_end), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .ch_cmp(ch_cmp),
        .ch_pol(ch_pol), .ch_en(ch_en), .top_val(top_val), .step_ready(step_ready)
    );

    function automatic logic [15:0] mem_word(logic [15:0] a);
        return (a * 16'd37 + 16'd11) ^ (a >> 3);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_valid <= 1'b0; mem_rdata <= '0; pend <= 0; pend_addr <= '0; req_cnt <= 0;
        end else begin
            mem_valid <= 1'b0;
            if (pend > 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    mem_valid <= 1'b1;
                    mem_rdata <= mem_word(pend_addr);
                end
            end
            if (clr_log) req_cnt <= 0;
            else if (mem_req) begin
                pend_addr <= mem_addr;
                pend <= lat;
                if (req_cnt < 8) req_log[req_cnt] <= mem_addr;
                req_cnt <= req_cnt + 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check_live(string tag);
        chk({ch_cmp, ch_pol, ch_en, top_val} == {exp_cmp, exp_pol, exp_en, exp_top}, tag,
            $sformatf("live act cmp=%h pol=%h en=%h top=%0d exp cmp=%h pol=%h en=%h top=%0d",
                      ch_cmp, ch_pol, ch_en, top_val, exp_cmp, exp_pol, exp_en, exp_top));
    endtask

    task automatic run_step(int m, logic [15:0] base, int idx, logic [14:0] top, bit disturb);
        int w;
        logic [15:0] s [0:3];
        string tag;
        w = (m == 0) ? 1 : (m == 1) ? 2 : 4;
        tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
        @(negedge clk);
        clr_log = 1'b1; load_mode = 2'(m); base_addr = base; step_idx = 8'(idx);
        reg_top = top; step_req = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; step_req = 1'b0;
        if (disturb) begin
            // R9 / R10: period end and stray request while fetching
            period_end = 1'b1; step_req = 1'b1; step_idx = 8'(idx + 5);
            @(negedge clk);
            period_end = 1'b0; step_req = 1'b0;
            check_live("R9");
        end
        for (int t = 0; t < 200 && !step_ready; t++) @(negedge clk);
        chk(step_ready, "R8", $sformatf("step_ready act=%0b exp=1", step_ready));
        // R2 / R10 / R11: address sequence and request count
        chk(req_cnt == w, disturb ? "R10" : "R11",
            $sformatf("read count act=%0d exp=%0d", req_cnt, w));
        for (int j = 0; j < w; j++) begin
            logic [15:0] ea;
            ea = base + 16'((idx * w + j) * 2);
            chk(req_log[j] == ea, "R2", $sformatf("addr[%0d] act=%h exp=%h", j, req_log[j], ea));
            s[j] = mem_word(ea);
        end
        // R8: nothing moves while waiting for period end; R7 reg_top taken late
        reg_top = top + 15'd1;
        repeat (3) @(negedge clk);
        check_live("R8");
        chk(step_ready, "R8", $sformatf("ready hold act=%0b exp=1", step_ready));
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
        for (int c = 0; c < 4; c++) begin
            logic [15:0] v;
            case (m)
                0: v = s[0];
                1: v = s[c/2];
                2: v = s[c];
                default: v = (c == 3) ? 16'h0 : s[c];
            endcase
            exp_cmp[c*15 +: 15] = v[14:0];
            exp_pol[c] = v[15];
        end
        exp_en  = (m == 3) ? 4'b0111 : 4'b1111;
        exp_top = (m == 3) ? s[3][14:0] : top + 15'd1;
        check_live(m == 3 ? tag : (idx == 2 ? "R7" : tag));
        chk(!step_ready, "R8", $sformatf("ready clear act=%0b exp=0", step_ready));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ch_cmp == '0 && ch_pol == '0 && ch_en == '0 && top_val == 15'd1023
            && !mem_req && !step_ready, "R1",
            $sformatf("reset act cmp=%h pol=%h en=%h top=%0d req=%0b rdy=%0b exp 0/0/0/1023/0/0",
                      ch_cmp, ch_pol, ch_en, top_val, mem_req, step_ready));
        for (int l = 0; l < 2; l++) begin
            lat = (l == 0) ? 1 : 3;
            for (int m = 0; m < 4; m++)
                for (int k = 0; k < 4; k++)
                    run_step(m, 16'h0100 + 16'(m * 64 + l * 8), k,
                             15'(100 + m * 10 + k), (l == 1) && (k == 1));
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end
endmodule